// File: doc/BRIEF.md
# Masked Global Power-Good Aggregator

This block merges six per-rail "in regulation" flags with system fault status into one global power-good indication. That indication drives an open-drain pull-down on a shared status line. Each rail's flag comes from an analog comparator that reports whether the rail is at or above 91% of its target. The flags arrive asynchronously, so each one passes through a two-stage synchronizer before it is used. The enable bits, the sequencing-complete flag, the thermal fault and the undervoltage-lockout flag are already synchronous to the block clock.

A per-rail mask register decides which rails take part. A masked rail can lose regulation or be disabled without affecting the global result. An unmasked rail that drops below threshold or is disabled pulls the global line low. Thermal and undervoltage faults always pull it low, whatever the masks hold. Nothing is reported good until the power-up sequencer signals completion. The mask register comes out of reset fully masked.

Leaving the mask bit of the last rail in the power-up order cleared keeps the line low until that rail is in regulation. Masking it lets the line rise as soon as sequencing completes.

Top module: `pg_aggregator`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `pg_pulldown` is 1. Every mask bit comes out of reset as 1 (masked). With `seq_done`=1, no faults and all rails low, the line therefore goes good one clock after reset.
- R2: The global state is good only when all of these hold: `seq_done`=1, `thermal_fault`=0, `uvlo`=0, and every unmasked rail i has both `out_en[i]`=1 and its synchronized good flag at 1.
- R3: When an unmasked enabled rail's raw good flag falls, `pg_pulldown` rises at the third rising clock edge after the change. The same latency applies when a flag rises.
- R4: A rail whose mask bit is 1 has no effect on `pg_pulldown`, whether its good flag or its enable changes.
- R5: `thermal_fault`=1 at a rising edge makes `pg_pulldown` 1 after that edge, for any mask value.
- R6: `uvlo`=1 at a rising edge makes `pg_pulldown` 1 after that edge, for any mask value.
- R7: `out_en[i]`=0 at a rising edge, with mask bit i at 0 before that edge, makes `pg_pulldown` 1 after that edge.
- R8: `mask_we`=1 at a rising edge loads `mask_wdata` into the mask register; bit i masks rail i. The new mask is first used at the following edge.
- R9: `seq_done`=0 at a rising edge makes `pg_pulldown` 1 after that edge, even with all rails good.
- R10: `pg_pulldown` is the inverse of the registered global good state: 1 means the line is pulled low (not good).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_good_raw | input | 6 | Asynchronous per-rail comparator flags, 1 = at or above 91% |
| out_en | input | 6 | Per-rail enable bits |
| seq_done | input | 1 | Power-up sequence complete |
| thermal_fault | input | 1 | Over-temperature fault |
| uvlo | input | 1 | Input undervoltage lockout active |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 6 | New mask value, 1 = rail ignored |
| pg_pulldown | output | 1 | Open-drain pull-down enable, 1 = line pulled low |

## Verification
A mask write and an enable change can land on the same rising edge. The evaluation at that edge uses the old mask, and the new mask only acts one edge later. The bench provokes this by setting a rail's mask bit in the same cycle that it clears that rail's enable while the line is good. It expects a one-cycle low pulse followed by recovery. A random phase also lets faults coincide with good-flag edges that are still inside the synchronizer. The behavioural model, with its own delay queue, judges every clock.

// File: rtl/pga_pkg.sv
package pga_pkg;

    // Synchronous system-level conditions feeding the combiner
    typedef struct packed {
        logic seq_done;
        logic thermal;
        logic uvlo;
    } pga_sys_t;

    // Registered state of the top level
    typedef struct packed {
        logic pg;
    } pga_state_t;

endpackage

// File: rtl/pga_sync.sv
module pga_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[LAST];
endmodule

// File: rtl/pga_mask_reg.sv
module pga_mask_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    logic [W-1:0] mask_d;
    logic [W-1:0] mask_q;

    always_comb begin
        mask_d = we ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask = mask_q;
endmodule

// File: rtl/pga_eval.sv
module pga_eval
    import pga_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] good,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mask,
    input  pga_sys_t     sys,
    output logic         pg_next
);
    logic [W-1:0] rail_ok;

    for (genvar i = 0; i < W; i++) begin : g_rail
        // masked rails always pass; others must be enabled and good
        assign rail_ok[i] = mask[i] | (en[i] & good[i]);
    end

    always_comb begin
        pg_next = sys.seq_done & ~sys.thermal & ~sys.uvlo & (&rail_ok);
    end
endmodule

// File: rtl/pg_aggregator.sv
module pg_aggregator
    import pga_pkg::*;
#(
    parameter int N_OUT       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] rail_good_raw,
    input  logic [N_OUT-1:0] out_en,
    input  logic             seq_done,
    input  logic             thermal_fault,
    input  logic             uvlo,
    input  logic             mask_we,
    input  logic [N_OUT-1:0] mask_wdata,
    output logic             pg_pulldown
);
    logic [N_OUT-1:0] good_sync;
    logic [N_OUT-1:0] mask_q;
    logic             pg_next;
    pga_sys_t         sys;
    pga_state_t       st_d;
    pga_state_t       st_q;

    pga_sync #(.W(N_OUT), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rail_good_raw),
        .dout  (good_sync)
    );

    pga_mask_reg #(.W(N_OUT)) mask_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (mask_wdata),
        .mask  (mask_q)
    );

    always_comb begin
        sys.seq_done = seq_done;
        sys.thermal  = thermal_fault;
        sys.uvlo     = uvlo;
    end

    pga_eval #(.W(N_OUT)) eval_i (
        .good    (good_sync),
        .en      (out_en),
        .mask    (mask_q),
        .sys     (sys),
        .pg_next (pg_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pg = pg_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pg_pulldown = ~st_q.pg;
endmodule

// File: rtl/pga_checker.sv
module pga_checker #(
    parameter int N_OUT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] out_en,
    input logic             seq_done,
    input logic             thermal_fault,
    input logic             uvlo,
    input logic             mask_we,
    input logic [N_OUT-1:0] mask_wdata,
    input logic [N_OUT-1:0] mask_q,
    input logic             pg_pulldown
);
    // R5
    thermal_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault |=> pg_pulldown);

    // R6
    uvlo_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> pg_pulldown);

    // R9
    seq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> pg_pulldown);

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R2
    good_needs_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pulldown) |-> ($past(seq_done) && !$past(thermal_fault) && !$past(uvlo)));

    for (genvar i = 0; i < N_OUT; i++) begin : g_en
        // R7
        unmasked_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_en[i] && !mask_q[i]) |=> pg_pulldown);
    end
endmodule

bind pg_aggregator pga_checker #(.N_OUT(N_OUT)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_en        (out_en),
    .seq_done      (seq_done),
    .thermal_fault (thermal_fault),
    .uvlo          (uvlo),
    .mask_we       (mask_we),
    .mask_wdata    (mask_wdata),
    .mask_q        (mask_q),
    .pg_pulldown   (pg_pulldown)
);

// File: tb/pg_aggregator_tb_top.sv
module pg_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] rail_good_raw = '0;
    logic [N-1:0] out_en = '1;
    logic         seq_done = 1'b0;
    logic         thermal_fault = 1'b0;
    logic         uvlo = 1'b0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         pg_pulldown;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_aggregator #(.N_OUT(N), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rail_good_raw (rail_good_raw),
        .out_en        (out_en),
        .seq_done      (seq_done),
        .thermal_fault (thermal_fault),
        .uvlo          (uvlo),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .pg_pulldown   (pg_pulldown)
    );

    // Behavioural reference: a two-deep history of raw flags and a mask copy
    logic [N-1:0] hist[$];
    logic [N-1:0] m_mask = '1;
    bit           m_pg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            hist.push_back('0);
            hist.push_back('0);
            m_mask = '1;
            m_pg = 0;
        end else begin
            logic [N-1:0] seen;
            bit ok;
            seen = hist.pop_front();
            hist.push_back(rail_good_raw);
            ok = 1;
            for (int i = 0; i < N; i++) begin
                if (!(m_mask[i] || (out_en[i] && seen[i]))) ok = 0;
            end
            m_pg = seq_done && !thermal_fault && !uvlo && ok;
            if (mask_we) m_mask = mask_wdata;
        end
    end

    // R10: compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (pg_pulldown !== !m_pg) begin
                n_bad++;
                $display("FAIL %s/R10 cycle compare: pg_pulldown=%0b expected=%0b",
                         cur_req, pg_pulldown, !m_pg);
            end
        end
    end

    task automatic chk(input logic exp, input string req);
        n_vec++;
        if (pg_pulldown !== exp) begin
            n_bad++;
            $display("FAIL %s: pg_pulldown=%0b expected=%0b", req, pg_pulldown, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        chk(1'b1, "R1 during reset");
        seq_done = 1'b0;
        rst_n = 1'b1;
        tick(1);
        chk(1'b1, "R1 first cycle after reset");

        // R9: sequence not done blocks good
        cur_req = "R9";
        rail_good_raw = '1;
        tick(5);
        chk(1'b1, "R9 seq_done low");

        // R1: default full mask lets line rise with rails low
        cur_req = "R1";
        rail_good_raw = '0;
        tick(3);
        seq_done = 1'b1;
        tick(1);
        chk(1'b0, "R1 reset mask all ones");

        // R8: clear mask, line drops one edge later
        cur_req = "R8";
        mask_we = 1'b1; mask_wdata = '0;
        tick(1);
        mask_we = 1'b0;
        chk(1'b0, "R8 old mask used at load edge");
        tick(1);
        chk(1'b1, "R8 new mask applied");

        // R2/R3: rising flags take three edges
        cur_req = "R3";
        rail_good_raw = '1;
        tick(2);
        chk(1'b1, "R3 still in synchronizer");
        tick(1);
        chk(1'b0, "R2 all unmasked good");

        // R3: falling flag on unmasked rail
        rail_good_raw[5] = 1'b0;
        tick(2);
        chk(1'b0, "R3 fall in synchronizer");
        tick(1);
        chk(1'b1, "R3 unmasked loss");
        rail_good_raw[5] = 1'b1;
        tick(4);

        // R4: masked rail loss and disable ignored
        cur_req = "R4";
        mask_we = 1'b1; mask_wdata = 6'b100000;
        tick(1);
        mask_we = 1'b0;
        rail_good_raw[5] = 1'b0;
        tick(5);
        chk(1'b0, "R4 masked loss ignored");
        out_en[5] = 1'b0;
        tick(3);
        chk(1'b0, "R4 masked disable ignored");
        out_en[5] = 1'b1;
        rail_good_raw[5] = 1'b1;

        // R5/R6: faults override full masking
        mask_we = 1'b1; mask_wdata = '1;
        tick(1);
        mask_we = 1'b0;
        cur_req = "R5";
        thermal_fault = 1'b1;
        tick(1);
        chk(1'b1, "R5 thermal");
        thermal_fault = 1'b0;
        tick(1);
        chk(1'b0, "R5 thermal released");
        cur_req = "R6";
        uvlo = 1'b1;
        tick(1);
        chk(1'b1, "R6 uvlo");
        uvlo = 1'b0;
        tick(1);
        chk(1'b0, "R6 uvlo released");

        // R7: disabling an unmasked rail
        cur_req = "R7";
        mask_we = 1'b1; mask_wdata = '0;
        tick(1);
        mask_we = 1'b0;
        tick(2);
        out_en[2] = 1'b0;
        tick(1);
        chk(1'b1, "R7 unmasked disable");
        out_en[2] = 1'b1;
        tick(1);
        chk(1'b0, "R7 re-enable");

        // Same edge: mask bit set while enable clears
        out_en[3] = 1'b0;
        mask_we = 1'b1; mask_wdata = 6'b001000;
        tick(1);
        mask_we = 1'b0;
        chk(1'b1, "R8 old mask at shared edge");
        tick(1);
        chk(1'b0, "R7 masked disable recovers");
        out_en[3] = 1'b1;

        // Random mix, judged by the model
        cur_req = "R2";
        for (int c = 0; c < 2000; c++) begin
            rail_good_raw = ($urandom_range(0, 7) == 0) ? N'($urandom) : '1;
            out_en        = ($urandom_range(0, 7) == 0) ? N'($urandom) : '1;
            seq_done      = ($urandom_range(0, 15) != 0);
            thermal_fault = ($urandom_range(0, 31) == 0);
            uvlo          = ($urandom_range(0, 31) == 0);
            mask_we       = ($urandom_range(0, 15) == 0);
            mask_wdata    = N'($urandom);
            tick(1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule